// File: doc/BRIEF.md
# Compositor Output Channel Sequencer

This block is the control and status logic of one output channel of a display compositor. Software sets an enable, a one-shot flag and the frame dimensions, and can pulse a self-clearing reset request. The pixel timing side supplies a vertical-start strobe, and the channel's output FIFO reports its fill level. Enabling the channel only arms it. Compositing starts at the next vertical-start strobe. A line and pixel counter stands in for the pixel datapath, producing one push into the FIFO per cycle whenever the FIFO has room.

In continuous mode the channel re-arms after every frame and waits for the next vertical start. In one-shot mode, which is used when the output feeds a writeback path, it composes a single frame and then parks. A reset request flushes the FIFO and forces the channel off. The reset indication reads back as zero once the FIFO has drained.

A 6-bit frame counter, a 2-bit mode field and registered FIFO full and empty flags form the channel status. A display-list start address can be written at any time. The channel takes it up at the next frame start without being disabled.

Top module: `compchan_top`

## Requirements
- R1: After the asynchronous reset `rstN`, the outputs are as follows: `statMode` is 0, `frameCount` is 0, `activeList` is 0, `resetBit` is 0, `statEmpty` is 1 and `statFull` is 0.
- R2: When `cfgEnable` is set in mode 0, the mode becomes 1 (armed) on the next cycle and no pixel is pushed. A `vStart` pulse seen in mode 1 with enable set moves the mode to 2 (compositing) on the next cycle.
- R3: In mode 2, `pixPush` is high in every cycle where `fifoLevel` is below DEPTH, and low while `fifoLevel` is at or above DEPTH. A frame consists of max(W,1)*max(H,1) pushes. W and H are sampled at the frame start.
- R4: With `cfgOneShot` clear, the cycle after the last push of a frame shows mode 1. A `vStart` arriving during mode 2 is ignored.
- R5: With `cfgOneShot` set at the last push, the mode becomes 3 (one-shot done). It then stays at 3 with no pushes, even if `vStart` arrives, until enable is cleared.
- R6: `frameCount` is 6 bits wide. It increments by one in the cycle after each last push and wraps from 63 to 0.
- R7: A `rstReq` pulse sets `resetBit` from the next cycle. While `resetBit` is set, `fifoFlush` is high, the mode is 0 and enable is ignored. `resetBit` clears in the cycle after one in which `fifoLevel` is 0. `rstReq` also clears `frameCount`. After the reset completes, the channel re-arms to mode 1 if enable is still set.
- R8: `statFull` (level >= DEPTH) and `statEmpty` (level == 0) are registered, so each reflects `fifoLevel` one cycle later.
- R9: A `listWr` stores `listAddr` as a pending address. `activeList` takes the pending address only at a frame start, and writing it never interrupts compositing.
- R10: Clearing `cfgEnable` stops pushes in the same cycle and gives mode 0 on the next cycle, from any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Channel enable |
| cfgOneShot | input | 1 | Compose a single frame, then park |
| cfgWidth | input | XW | Frame width in pixels |
| cfgHeight | input | YW | Frame height in lines |
| rstReq | input | 1 | Self-clearing channel reset request (pulse) |
| vStart | input | 1 | Vertical-start strobe |
| listWr | input | 1 | Display-list address write strobe |
| listAddr | input | AW | Display-list start address to write |
| fifoLevel | input | LVLW | Current output FIFO fill level |
| pixPush | output | 1 | Push one composed pixel into the FIFO |
| fifoFlush | output | 1 | Flush request to the FIFO |
| statMode | output | 2 | 0 off, 1 armed, 2 compositing, 3 one-shot done |
| statFull | output | 1 | Registered FIFO-full flag |
| statEmpty | output | 1 | Registered FIFO-empty flag |
| resetBit | output | 1 | Reset still in progress |
| frameCount | output | FCW | Completed-frame counter |
| activeList | output | AW | Display-list address in use |

## Verification
The bench covers the following corner cases, and each one catches a specific class of faulty design:
- Back-pressure in the middle of a frame: a design that ignored the FIFO level would overrun it and finish the frame early.
- A reset held open by a non-empty FIFO: a design that cleared its reset indication on a timer would report completion before the flush.
- Zero-sized dimension fields: a design that did not clamp them would compose a frame that never ends.
- A list address written mid-frame: a design that applied it at once would change `activeList` inside the frame.
- One-shot parking under a repeated vertical start, and back-to-back 1x1 frames past 63: these expose a design that re-arms after a one-shot frame or saturates the frame counter.

// File: rtl/compchan_pkg.sv
package compchan_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_ARMED = 2'd1,
    MODE_RUN   = 2'd2,
    MODE_DONE  = 2'd3
  } chanMode_e;

  typedef struct packed {
    logic frameStart;
    logic pixStep;
    logic clearAll;
  } dpStrobe_t;

endpackage

// File: rtl/compchan_ctrl.sv
module compchan_ctrl
  import compchan_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgEnable,
  input  logic      cfgOneShot,
  input  logic      rstReq,
  input  logic      vStart,
  input  logic      fullNow,
  input  logic      zeroNow,
  input  logic      frameLast,
  output dpStrobe_t strobe,
  output chanMode_e mode,
  output logic      resetBit
);

  logic      rstAct;
  logic      resetNext;
  chanMode_e modeNext;

  always_comb begin
    rstAct            = rstReq | resetBit;
    strobe.clearAll   = rstReq;
    strobe.frameStart = !rstAct && (mode == MODE_ARMED) && cfgEnable && vStart;
    strobe.pixStep    = !rstAct && (mode == MODE_RUN) && cfgEnable && !fullNow;
  end

  always_comb begin
    if (rstReq)                   resetNext = 1'b1;
    else if (resetBit && zeroNow) resetNext = 1'b0;
    else                          resetNext = resetBit;
  end

  always_comb begin
    modeNext = mode;
    if (rstAct) begin
      modeNext = MODE_OFF;
    end else begin
      case (mode)
        MODE_OFF:   if (cfgEnable) modeNext = MODE_ARMED;
        MODE_ARMED: begin
          if (!cfgEnable)  modeNext = MODE_OFF;
          else if (vStart) modeNext = MODE_RUN;
        end
        MODE_RUN: begin
          if (!cfgEnable)                       modeNext = MODE_OFF;
          else if (strobe.pixStep && frameLast) modeNext = cfgOneShot ? MODE_DONE : MODE_ARMED;
        end
        MODE_DONE:  if (!cfgEnable) modeNext = MODE_OFF;
        default:    modeNext = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MODE_OFF;
      resetBit <= 1'b0;
    end else begin
      mode     <= modeNext;
      resetBit <= resetNext;
    end
  end

  AST_RESET_FORCES_OFF: assert property (@(posedge clk) disable iff (!rstN)
    resetBit |=> mode == MODE_OFF); // R7
  AST_RESET_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (resetBit && zeroNow && !rstReq) |=> !resetBit); // R7
  AST_ARMED_WAITS_VSTART: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_ARMED && !vStart) |=> mode != MODE_RUN); // R2
  AST_ONESHOT_PARKS: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_DONE && cfgEnable && !rstReq && !resetBit) |=> mode == MODE_DONE); // R5
  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> mode == MODE_OFF || $past(mode) == MODE_OFF); // R10

endmodule

// File: rtl/compchan_dp.sv
module compchan_dp
  import compchan_pkg::*;
#(
  parameter int XW  = 12,
  parameter int YW  = 12,
  parameter int FCW = 6,
  parameter int AW  = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpStrobe_t      strobe,
  input  logic [XW-1:0]  cfgWidth,
  input  logic [YW-1:0]  cfgHeight,
  input  logic           listWr,
  input  logic [AW-1:0]  listAddr,
  input  logic           fullNow,
  input  logic           zeroNow,
  output logic           frameLast,
  output logic [FCW-1:0] frameCount,
  output logic [AW-1:0]  activeList,
  output logic           statFull,
  output logic           statEmpty
);

  logic [XW-1:0] xCnt, lastX, lastXNew;
  logic [YW-1:0] yCnt, lastY, lastYNew;
  logic [AW-1:0] pendingList;

  always_comb begin
    lastXNew  = (cfgWidth  == '0) ? '0 : cfgWidth  - 1'b1;
    lastYNew  = (cfgHeight == '0) ? '0 : cfgHeight - 1'b1;
    frameLast = (xCnt == lastX) && (yCnt == lastY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xCnt        <= '0;
      yCnt        <= '0;
      lastX       <= '0;
      lastY       <= '0;
      pendingList <= '0;
      activeList  <= '0;
      frameCount  <= '0;
      statFull    <= 1'b0;
      statEmpty   <= 1'b1;
    end else begin
      statFull  <= fullNow;
      statEmpty <= zeroNow;
      if (listWr) pendingList <= listAddr;
      if (strobe.clearAll)                    frameCount <= '0;
      else if (strobe.pixStep && frameLast)   frameCount <= frameCount + 1'b1;
      if (strobe.frameStart) begin
        xCnt       <= '0;
        yCnt       <= '0;
        lastX      <= lastXNew;
        lastY      <= lastYNew;
        activeList <= pendingList;
      end else if (strobe.pixStep) begin
        if (xCnt == lastX) begin
          xCnt <= '0;
          yCnt <= yCnt + 1'b1;
        end else begin
          xCnt <= xCnt + 1'b1;
        end
      end
    end
  end

  AST_COUNT_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(frameCount) |-> ($past(strobe.pixStep && frameLast) || $past(strobe.clearAll))); // R6
  AST_LIST_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.frameStart |=> $stable(activeList)); // R9
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(statFull && statEmpty)); // R8

endmodule

// File: rtl/compchan_top.sv
module compchan_top
  import compchan_pkg::*;
#(
  parameter int XW    = 12,
  parameter int YW    = 12,
  parameter int FCW   = 6,
  parameter int AW    = 16,
  parameter int DEPTH = 16,
  parameter int LVLW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgEnable,
  input  logic            cfgOneShot,
  input  logic [XW-1:0]   cfgWidth,
  input  logic [YW-1:0]   cfgHeight,
  input  logic            rstReq,
  input  logic            vStart,
  input  logic            listWr,
  input  logic [AW-1:0]   listAddr,
  input  logic [LVLW-1:0] fifoLevel,
  output logic            pixPush,
  output logic            fifoFlush,
  output logic [1:0]      statMode,
  output logic            statFull,
  output logic            statEmpty,
  output logic            resetBit,
  output logic [FCW-1:0]  frameCount,
  output logic [AW-1:0]   activeList
);

  localparam logic [LVLW-1:0] FullLevel = LVLW'(DEPTH);

  dpStrobe_t strobe;
  chanMode_e mode;
  logic      fullNow, zeroNow, frameLast;

  assign fullNow = fifoLevel >= FullLevel;
  assign zeroNow = fifoLevel == '0;

  compchan_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgEnable  (cfgEnable),
    .cfgOneShot (cfgOneShot),
    .rstReq     (rstReq),
    .vStart     (vStart),
    .fullNow    (fullNow),
    .zeroNow    (zeroNow),
    .frameLast  (frameLast),
    .strobe     (strobe),
    .mode       (mode),
    .resetBit   (resetBit)
  );

  compchan_dp #(.XW(XW), .YW(YW), .FCW(FCW), .AW(AW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgWidth   (cfgWidth),
    .cfgHeight  (cfgHeight),
    .listWr     (listWr),
    .listAddr   (listAddr),
    .fullNow    (fullNow),
    .zeroNow    (zeroNow),
    .frameLast  (frameLast),
    .frameCount (frameCount),
    .activeList (activeList),
    .statFull   (statFull),
    .statEmpty  (statEmpty)
  );

  assign pixPush   = strobe.pixStep;
  assign fifoFlush = resetBit;
  assign statMode  = mode;

  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    fullNow |-> !pixPush); // R3
  AST_NO_PUSH_IN_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    fifoFlush |-> !pixPush); // R7

endmodule

// File: tb/compchan_top_bench.sv
module compchan_top_bench;

  localparam int XW = 12, YW = 12, FCW = 6, AW = 16, DEPTH = 16;
  localparam int LVLW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 0, cfgOneShot = 0, rstReq = 0, vStart = 0, listWr = 0;
  logic [XW-1:0] cfgWidth = '0;
  logic [YW-1:0] cfgHeight = '0;
  logic [AW-1:0] listAddr = '0;
  logic [LVLW-1:0] fifoLevel = '0;
  logic pixPush, fifoFlush, statFull, statEmpty, resetBit;
  logic [1:0] statMode;
  logic [FCW-1:0] frameCount;
  logic [AW-1:0] activeList;

  int checkCount = 0;
  int failCount = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  compchan_top u_compchan_top (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgOneShot(cfgOneShot),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight), .rstReq(rstReq), .vStart(vStart),
    .listWr(listWr), .listAddr(listAddr), .fifoLevel(fifoLevel),
    .pixPush(pixPush), .fifoFlush(fifoFlush), .statMode(statMode),
    .statFull(statFull), .statEmpty(statEmpty), .resetBit(resetBit),
    .frameCount(frameCount), .activeList(activeList)
  );

  // Behavioural reference model
  int mMode, mCount, mActive, mPending, pixLeft;
  bit mReset, mFull, mEmpty;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mCount = 0; mActive = 0; mPending = 0; pixLeft = 0;
      mReset = 0; mFull = 0; mEmpty = 1;
    end else begin
      bit rstAct, push, nReset;
      int w, h;
      rstAct = rstReq || mReset;
      push = (mMode == 2) && cfgEnable && !rstAct && (fifoLevel < DEPTH);
      nReset = rstReq ? 1 : ((mReset && fifoLevel == 0) ? 0 : mReset);
      mFull = fifoLevel >= DEPTH;
      mEmpty = fifoLevel == 0;
      if (rstReq) mCount = 0;
      if (rstAct) mMode = 0;
      else if (mMode == 0) begin
        if (cfgEnable) mMode = 1;
      end else if (mMode == 1) begin
        if (!cfgEnable) mMode = 0;
        else if (vStart) begin
          w = (cfgWidth == 0) ? 1 : int'(cfgWidth);
          h = (cfgHeight == 0) ? 1 : int'(cfgHeight);
          pixLeft = w * h;
          mActive = mPending;
          mMode = 2;
        end
      end else if (mMode == 2) begin
        if (!cfgEnable) mMode = 0;
        else if (push) begin
          pixLeft = pixLeft - 1;
          if (pixLeft == 0) begin
            mCount = (mCount + 1) % 64;
            mMode = cfgOneShot ? 3 : 1;
          end
        end
      end else begin
        if (!cfgEnable) mMode = 0;
      end
      if (listWr) mPending = int'(listAddr);
      mReset = nReset;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit expPush;
    expPush = rstN && (mMode == 2) && cfgEnable && !(rstReq || mReset) && (fifoLevel < DEPTH);
    chk(statMode == mMode[1:0], "R2/R4/R5/R10", "mode", int'(statMode), mMode);
    chk(pixPush == expPush, "R3", "push", int'(pixPush), int'(expPush));
    chk(frameCount == mCount[FCW-1:0], "R6", "frameCount", int'(frameCount), mCount);
    chk(activeList == mActive[AW-1:0], "R9", "activeList", int'(activeList), mActive);
    chk(resetBit == mReset, "R7", "resetBit", int'(resetBit), int'(mReset));
    chk(fifoFlush == mReset, "R7", "flush", int'(fifoFlush), int'(mReset));
    chk(statFull == mFull, "R8", "full", int'(statFull), int'(mFull));
    chk(statEmpty == mEmpty, "R8", "empty", int'(statEmpty), int'(mEmpty));
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic pulseVs();
    vStart = 1; cyc(1); vStart = 0;
  endtask

  initial begin
    bit sawWrap;
    int prevCount;
    cyc(3);
    rstN = 1;
    cyc(1);
    chk(statMode == 0, "R1", "mode", int'(statMode), 0);
    chk(frameCount == 0, "R1", "frameCount", int'(frameCount), 0);
    chk(activeList == 0 && !resetBit, "R1", "list/reset", int'(activeList), 0);
    chk(statEmpty && !statFull, "R1", "flags", int'(statEmpty), 1);

    // R2, R3, R4, R9: continuous frames, back-pressure, list update mid-frame
    listWr = 1; listAddr = 16'h1234; cyc(1); listWr = 0;
    cfgWidth = 4; cfgHeight = 2; cfgEnable = 1; cyc(3);
    chk(statMode == 1, "R2", "armed", int'(statMode), 1);
    pulseVs(); cyc(3);
    fifoLevel = DEPTH; cyc(3);
    fifoLevel = 5; listWr = 1; listAddr = 16'hBEEF; cyc(1); listWr = 0;
    vStart = 1; cyc(2); vStart = 0;
    cyc(8);
    chk(activeList == 16'h1234, "R9", "held list", int'(activeList), 16'h1234);
    pulseVs(); cyc(1);
    chk(activeList == 16'hBEEF, "R9", "new list", int'(activeList), 16'hBEEF);
    cyc(12);

    // R10: disable mid-frame
    pulseVs(); cyc(2); cfgEnable = 0; cyc(3);
    chk(statMode == 0, "R10", "off", int'(statMode), 0);

    // R5: one-shot
    cfgOneShot = 1; cfgEnable = 1; cfgWidth = 3; cfgHeight = 1; cyc(1);
    pulseVs(); cyc(6);
    vStart = 1; cyc(3); vStart = 0;
    chk(statMode == 3, "R5", "parked", int'(statMode), 3);
    cfgEnable = 0; cyc(2); cfgOneShot = 0;

    // R3: zero dimensions clamp to 1x1
    cfgWidth = 0; cfgHeight = 0; cfgEnable = 1; fifoLevel = 0; cyc(1);
    pulseVs(); cyc(3);

    // R7: reset held by non-empty FIFO, enable held high
    fifoLevel = 7; cfgWidth = 8; cfgHeight = 4; pulseVs(); cyc(1);
    rstReq = 1; cyc(1); rstReq = 0; cyc(4);
    chk(resetBit && fifoFlush, "R7", "reset pending", int'(resetBit), 1);
    fifoLevel = 0; cyc(3);
    chk(statMode == 1 && !resetBit, "R7", "rearmed", int'(statMode), 1);
    cfgEnable = 0; rstReq = 1; cyc(1); rstReq = 0; cyc(3);
    chk(statMode == 0 && statEmpty && !statFull, "R7", "off after reset", int'(statMode), 0);

    // R6: wrap of the frame counter with back-to-back 1x1 frames
    cfgWidth = 1; cfgHeight = 1; cfgEnable = 1; vStart = 1;
    sawWrap = 0;
    for (int i = 0; i < 140; i++) begin
      prevCount = int'(frameCount);
      cyc(1);
      if (prevCount == 63 && frameCount == 0) sawWrap = 1;
    end
    vStart = 0; cfgEnable = 0; cyc(3);
    chk(sawWrap, "R6", "wrap seen", int'(sawWrap), 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checkCount++; failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule